// File: doc/BRIEF.md
# Strided Vector Load Sequencer

This block walks a strided vector load across an interleaved memory made of several single-ported banks. Software-side logic presents a base word address, a signed-free stride (addresses wrap modulo the address width), an element count and a one-cycle start strobe. The sequencer then issues the element addresses one at a time, `base + k*stride`, at no more than one request per cycle. It returns the element data in order, each tagged with its index.

Banks are selected by the low address bits, with the bank count a power of two. After a bank accepts a request it stays occupied for a fixed number of cycles. Each bank carries a countdown, and a request whose bank is still counting down is held until the bank frees. A load that rotates through enough banks therefore streams one element per cycle. A stride that keeps landing on the same bank, such as a multiple of the bank count or zero, serialises at the bank occupancy time.

The memory answers each request on the following cycle. The sequencer delays that word so that every element leaves a fixed latency after its request. A completion pulse accompanies the final element.

Top module: `strided_vload_ctrl`

## Requirements
- R1: While rst_ni is low, busy_o, mem_req_o, vld_o and done_o are all 0.
- R2: A start_i pulse with a nonzero len_i, seen while busy_o is 0, is accepted at that clock edge. busy_o is 1 from the next cycle, and the first request (address base_i) is issued no earlier than that cycle.
- R3: Element k is requested at word address (base_i + k*stride_i) mod 2^ADDR_W. Requests go out in increasing k, at most one per cycle, exactly len_i of them.
- R4: The bank of a request is mem_addr_o mod NUM_BANKS. No two requests to the same bank are closer than BUSY_CYC cycles apart.
- R5: A pending request is issued in the first cycle in which its bank is free, so a load whose banks never conflict issues in len_i consecutive cycles.
- R6: The element requested in cycle c appears on vld_o/vidx_o/vdata_o in cycle c+MEM_LAT. vdata_o carries the mem_rdata_i word presented in cycle c+1, and vidx_o carries the element index k.
- R7: done_o is a one-cycle pulse coinciding with the vld_o of the last element. busy_o is 0 in the following cycle.
- R8: With the default parameters, a 64-element load completes (done_o) 76 cycles after its start edge for stride 1 and 391 cycles after it for stride 32.
- R9: A stride of 0 is legal. Every element then targets the same bank, and element k is requested exactly k*BUSY_CYC cycles after element 0.
- R10: A start_i pulse seen while busy_o is 1, or carrying len_i of 0, is ignored. No extra requests or elements appear and the running load is unaffected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start strobe for a new load |
| base_i | input | ADDR_W | First element word address |
| stride_i | input | ADDR_W | Address step between elements |
| len_i | input | LEN_W | Number of elements |
| busy_o | output | 1 | Load in progress (issuing or data in flight) |
| mem_req_o | output | 1 | Read request to the banked memory |
| mem_addr_o | output | ADDR_W | Request word address; low bits pick the bank |
| mem_rdata_i | input | DATA_W | Read word, valid the cycle after its request |
| vld_o | output | 1 | Returned element valid |
| vidx_o | output | LEN_W | Index of the returned element |
| vdata_o | output | DATA_W | Returned element data |
| done_o | output | 1 | Pulses with the last element of a load |

## Verification
The bench builds the block with its defaults: 8 banks, 6 busy cycles, 12 cycles of latency and 16-bit addresses. These values make the 76-cycle and 391-cycle totals for 64-element loads directly checkable. The same bank count lets strides of 2 and 6 revisit a bank every 4 accesses, which is inside the busy window and forces partial stalls. Strides of 1, 3 and 5 never collide. A base near the top of the address space exercises the address wrap. Stride 0 and stride 32 pin a single bank.

// File: rtl/svl_pkg.sv
package svl_pkg;
  typedef enum logic {
    SEQ_IDLE = 1'b0,
    SEQ_RUN  = 1'b1
  } seq_state_e;
endpackage

// File: rtl/svl_bank_track.sv
module svl_bank_track #(
  parameter int unsigned NUM_BANKS = 8,
  parameter int unsigned BUSY_CYC  = 6
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         hit_i,
  input  logic [$clog2(NUM_BANKS)-1:0] bank_i,
  output logic                         free_o
);
  localparam int unsigned BANK_W = $clog2(NUM_BANKS);
  localparam int unsigned CNT_W  = $clog2(BUSY_CYC + 1);
  // issue cycle counts as the first busy cycle
  localparam logic [CNT_W-1:0] LOAD_V = CNT_W'(BUSY_CYC - 1);

  logic [NUM_BANKS-1:0] zero_q;

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic [CNT_W-1:0] cnt_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        cnt_q <= '0;
      end else if (hit_i && bank_i == BANK_W'(b)) begin
        cnt_q <= LOAD_V;
      end else if (cnt_q != '0) begin
        cnt_q <= cnt_q - 1'b1;
      end
    end
    assign zero_q[b] = (cnt_q == '0);
  end

  assign free_o = zero_q[bank_i];
endmodule

// File: rtl/svl_addr_gen.sv
module svl_addr_gen import svl_pkg::*; #(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned LEN_W  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              idle_i,
  input  logic [ADDR_W-1:0] base_i,
  input  logic [ADDR_W-1:0] stride_i,
  input  logic [LEN_W-1:0]  len_i,
  input  logic              bank_free_i,
  output logic              active_o,
  output logic              req_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [LEN_W-1:0]  idx_o,
  output logic              last_o
);
  seq_state_e        state_q;
  logic [ADDR_W-1:0] addr_q, stride_q;
  logic [LEN_W-1:0]  rem_q, idx_q;

  assign active_o = (state_q == SEQ_RUN);
  assign req_o    = active_o & bank_free_i;
  assign addr_o   = addr_q;
  assign idx_o    = idx_q;
  assign last_o   = (rem_q == LEN_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= SEQ_IDLE;
      addr_q   <= '0;
      stride_q <= '0;
      rem_q    <= '0;
      idx_q    <= '0;
    end else if (state_q == SEQ_IDLE) begin
      if (start_i && idle_i && len_i != '0) begin
        state_q  <= SEQ_RUN;
        addr_q   <= base_i;
        stride_q <= stride_i;
        rem_q    <= len_i;
        idx_q    <= '0;
      end
    end else if (req_o) begin
      addr_q <= addr_q + stride_q;
      idx_q  <= idx_q + 1'b1;
      rem_q  <= rem_q - 1'b1;
      if (last_o) state_q <= SEQ_IDLE;
    end
  end
endmodule

// File: rtl/svl_ret_pipe.sv
module svl_ret_pipe #(
  parameter int unsigned MEM_LAT = 12,
  parameter int unsigned LEN_W   = 8,
  parameter int unsigned DATA_W  = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              push_i,
  input  logic [LEN_W-1:0]  idx_i,
  input  logic              last_i,
  input  logic [DATA_W-1:0] rdata_i,
  output logic              any_o,
  output logic              vld_o,
  output logic [LEN_W-1:0]  idx_o,
  output logic              last_o,
  output logic [DATA_W-1:0] data_o
);
  // stage 0 holds the tag while memory reads; data joins at stage 1
  logic [MEM_LAT-1:0] vld_q, last_q;
  logic [LEN_W-1:0]   idx_q  [MEM_LAT];
  logic [DATA_W-1:0]  data_q [1:MEM_LAT-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q  <= '0;
      last_q <= '0;
      for (int j = 0; j < MEM_LAT; j++) idx_q[j] <= '0;
      for (int j = 1; j < MEM_LAT; j++) data_q[j] <= '0;
    end else begin
      vld_q    <= {vld_q[MEM_LAT-2:0], push_i};
      last_q   <= {last_q[MEM_LAT-2:0], push_i & last_i};
      idx_q[0] <= idx_i;
      for (int j = 1; j < MEM_LAT; j++) idx_q[j] <= idx_q[j-1];
      data_q[1] <= rdata_i;
      for (int j = 2; j < MEM_LAT; j++) data_q[j] <= data_q[j-1];
    end
  end

  assign any_o  = |vld_q;
  assign vld_o  = vld_q[MEM_LAT-1];
  assign last_o = last_q[MEM_LAT-1];
  assign idx_o  = idx_q[MEM_LAT-1];
  assign data_o = data_q[MEM_LAT-1];
endmodule

// File: rtl/strided_vload_ctrl.sv
module strided_vload_ctrl #(
  parameter int unsigned NUM_BANKS = 8,
  parameter int unsigned BUSY_CYC  = 6,
  parameter int unsigned MEM_LAT   = 12,
  parameter int unsigned ADDR_W    = 16,
  parameter int unsigned LEN_W     = 8,
  parameter int unsigned DATA_W    = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] base_i,
  input  logic [ADDR_W-1:0] stride_i,
  input  logic [LEN_W-1:0]  len_i,
  output logic              busy_o,
  output logic              mem_req_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  input  logic [DATA_W-1:0] mem_rdata_i,
  output logic              vld_o,
  output logic [LEN_W-1:0]  vidx_o,
  output logic [DATA_W-1:0] vdata_o,
  output logic              done_o
);
  localparam int unsigned BANK_W = $clog2(NUM_BANKS);

  logic             gen_active, pipe_any, bank_free, issue, issue_last, out_last;
  logic [LEN_W-1:0] issue_idx;

  assign busy_o = gen_active | pipe_any;

  svl_addr_gen #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_gen (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start_i),
    .idle_i      (~busy_o),
    .base_i      (base_i),
    .stride_i    (stride_i),
    .len_i       (len_i),
    .bank_free_i (bank_free),
    .active_o    (gen_active),
    .req_o       (issue),
    .addr_o      (mem_addr_o),
    .idx_o       (issue_idx),
    .last_o      (issue_last)
  );

  svl_bank_track #(.NUM_BANKS(NUM_BANKS), .BUSY_CYC(BUSY_CYC)) u_banks (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .hit_i  (issue),
    .bank_i (mem_addr_o[BANK_W-1:0]),
    .free_o (bank_free)
  );

  svl_ret_pipe #(.MEM_LAT(MEM_LAT), .LEN_W(LEN_W), .DATA_W(DATA_W)) u_ret (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .push_i  (issue),
    .idx_i   (issue_idx),
    .last_i  (issue_last),
    .rdata_i (mem_rdata_i),
    .any_o   (pipe_any),
    .vld_o   (vld_o),
    .idx_o   (vidx_o),
    .last_o  (out_last),
    .data_o  (vdata_o)
  );

  assign mem_req_o = issue;
  assign done_o    = vld_o & out_last;
endmodule

// File: rtl/svl_chk.sv
module svl_chk #(
  parameter int unsigned NUM_BANKS = 8,
  parameter int unsigned BUSY_CYC  = 6
) (
  input logic                         clk_i,
  input logic                         rst_ni,
  input logic                         start_i,
  input logic                         len_nz_i,
  input logic                         busy_o,
  input logic                         mem_req_o,
  input logic [$clog2(NUM_BANKS)-1:0] bank_i,
  input logic                         vld_o,
  input logic                         done_o
);
  localparam int unsigned CNT_W = $clog2(BUSY_CYC + 1);

  // cycles since the last request to each bank, saturating at BUSY_CYC
  logic [CNT_W-1:0] since_q [NUM_BANKS];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int b = 0; b < NUM_BANKS; b++) since_q[b] <= CNT_W'(BUSY_CYC);
    end else begin
      for (int b = 0; b < NUM_BANKS; b++) begin
        if (mem_req_o && bank_i == b[$clog2(NUM_BANKS)-1:0]) since_q[b] <= CNT_W'(1);
        else if (since_q[b] < CNT_W'(BUSY_CYC)) since_q[b] <= since_q[b] + 1'b1;
      end
    end
  end

  // R4
  bank_gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> (since_q[bank_i] >= CNT_W'(BUSY_CYC)));

  // R2
  start_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && len_nz_i && !busy_o) |=> busy_o);

  // R7
  done_with_vld_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> vld_o);

  // R7
  done_then_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !busy_o);

  // R6
  idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> (!mem_req_o && !vld_o));
endmodule

bind strided_vload_ctrl svl_chk #(.NUM_BANKS(NUM_BANKS), .BUSY_CYC(BUSY_CYC)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .start_i   (start_i),
  .len_nz_i  (|len_i),
  .busy_o    (busy_o),
  .mem_req_o (mem_req_o),
  .bank_i    (mem_addr_o[BANK_W-1:0]),
  .vld_o     (vld_o),
  .done_o    (done_o)
);

// File: tb/tb_strided_vload_ctrl.sv
module tb_strided_vload_ctrl;
  localparam int NB = 8, BUSY = 6, LAT = 12, AW = 16, LW = 8, DW = 32;

  logic          clk = 1'b0, rst_n = 1'b0;
  logic          start = 1'b0;
  logic [AW-1:0] base = '0, stride = '0;
  logic [LW-1:0] len = '0;
  logic [DW-1:0] rdata = '0;
  logic          busy, mreq, vld, done;
  logic [AW-1:0] maddr;
  logic [LW-1:0] vidx;
  logic [DW-1:0] vdata;

  always #2 clk = ~clk;

  strided_vload_ctrl dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .base_i(base), .stride_i(stride),
    .len_i(len), .busy_o(busy), .mem_req_o(mreq), .mem_addr_o(maddr),
    .mem_rdata_i(rdata), .vld_o(vld), .vidx_o(vidx), .vdata_o(vdata), .done_o(done)
  );

  function automatic logic [DW-1:0] memf(logic [AW-1:0] a);
    return (32'(a) * 32'h0000_9e37) ^ 32'h5a5a_1234;
  endfunction

  // behavioural bank storage, one-cycle read
  always @(posedge clk) if (mreq) rdata <= memf(maddr);

  int n_chk = 0, n_fail = 0, cyc = 0, wd = 0;
  bit finished = 0;

  // reference model state
  bit            m_act = 0;
  logic [AW-1:0] m_addr, m_stride;
  int            m_rem, m_idx;
  int            bank_free [NB];
  int            q_due[$], q_idx[$], q_last[$];
  logic [DW-1:0] q_dat[$];
  int            start_cyc, done_cyc, vcount, first_req_cyc, req_cyc[$];

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    wd++;
    if (wd > 150000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", wd, 150000);
      finish_run();
    end
  end

  function automatic bit m_busy();
    return m_act || (q_due.size() > 0);
  endfunction

  // one cycle: compare at negedge, then drive inputs and advance model
  task automatic step(input bit s, input logic [AW-1:0] b, input logic [AW-1:0] st,
                      input logic [LW-1:0] l);
    bit e_req, e_vld, e_busy;
    int bk;
    @(negedge clk);
    cyc++;
    bk     = int'(m_addr) % NB;
    e_busy = m_busy();
    e_req  = m_act && (bank_free[bk] <= cyc);
    e_vld  = (q_due.size() > 0) && (q_due[0] == cyc);
    chk(busy == e_busy, "R2 busy_o", busy, e_busy);
    chk(mreq == e_req, "R4 R5 mem_req_o", mreq, e_req);
    if (e_req && mreq) chk(maddr == m_addr, "R3 mem_addr_o", maddr, m_addr);
    chk(vld == e_vld, "R6 vld_o", vld, e_vld);
    if (e_vld && vld) begin
      chk(vidx == LW'(q_idx[0]), "R6 vidx_o", vidx, q_idx[0]);
      chk(vdata == q_dat[0], "R6 vdata_o", vdata, q_dat[0]);
    end
    chk(done == (e_vld && q_last[0] == 1), "R7 done_o", done, e_vld && q_last[0] == 1);
    if (vld) vcount++;
    if (done) done_cyc = cyc;
    // model edge update
    if (e_vld) begin
      void'(q_due.pop_front()); void'(q_idx.pop_front());
      void'(q_last.pop_front()); void'(q_dat.pop_front());
    end
    if (e_req) begin
      bank_free[bk] = cyc + BUSY;
      req_cyc.push_back(cyc);
      q_due.push_back(cyc + LAT); q_idx.push_back(m_idx);
      q_last.push_back(m_rem == 1 ? 1 : 0); q_dat.push_back(memf(m_addr));
      m_addr = m_addr + m_stride; m_idx++; m_rem--;
      if (m_rem == 0) m_act = 0;
    end
    if (s && !e_busy && l != 0) begin
      m_act = 1; m_addr = b; m_stride = st; m_rem = int'(l); m_idx = 0;
      start_cyc = cyc; vcount = 0; req_cyc.delete();
    end
    start = s; base = b; stride = st; len = l;
  endtask

  task automatic run(input logic [AW-1:0] b, input logic [AW-1:0] st, input int l,
                     input int poke);
    int n = 0;
    step(1'b1, b, st, LW'(l));
    while (m_busy() && n < 5000) begin
      n++;
      if (poke > 0 && n == poke) step(1'b1, b ^ 16'h0abc, st + 16'd1, LW'(3));
      else step(1'b0, '0, '0, '0);
    end
    step(1'b0, '0, '0, '0);
    chk(vcount == l, "R3 element count", vcount, l);
  endtask

  initial begin
    for (int i = 0; i < NB; i++) bank_free[i] = 0;
    m_addr = '0; m_stride = '0; m_rem = 0; m_idx = 0;
    #9;
    // R1
    chk(busy == 0, "R1 busy_o in reset", busy, 0);
    chk(mreq == 0, "R1 mem_req_o in reset", mreq, 0);
    chk(vld == 0, "R1 vld_o in reset", vld, 0);
    chk(done == 0, "R1 done_o in reset", done, 0);
    @(negedge clk); rst_n = 1'b1;
    for (int i = 0; i < 3; i++) step(1'b0, '0, '0, '0);

    // R2 R5 R8: unit stride streams without stalls
    run(16'h0100, 16'd1, 64, 0);
    chk(req_cyc[0] == start_cyc + 1, "R2 first request cycle", req_cyc[0] - start_cyc, 1);
    chk(done_cyc - start_cyc == 76, "R5 R8 stride 1 duration", done_cyc - start_cyc, 76);

    // R8: same bank every access
    run(16'h0040, 16'd32, 64, 0);
    chk(done_cyc - start_cyc == 391, "R8 stride 32 duration", done_cyc - start_cyc, 391);

    // R9: zero stride
    run(16'h0003, 16'd0, 5, 0);
    for (int k = 1; k < 5; k++)
      chk(req_cyc[k] - req_cyc[0] == k * BUSY, "R9 stride 0 spacing",
          req_cyc[k] - req_cyc[0], k * BUSY);
    chk(done_cyc - start_cyc == 12 + 1 + 6 * 4, "R9 stride 0 duration",
        done_cyc - start_cyc, 37);

    // R4: partial conflicts; R5: conflict-free odd strides; R3: address wrap
    run(16'h0010, 16'd2, 20, 0);
    run(16'h0201, 16'd6, 17, 0);
    run(16'h0007, 16'd3, 30, 0);
    chk(done_cyc - start_cyc == 12 + 30, "R5 stride 3 duration", done_cyc - start_cyc, 42);
    run(16'hfff0, 16'd5, 40, 0);
    run(16'h0007, 16'd9, 1, 0);
    chk(done_cyc - start_cyc == 13, "R7 single element done", done_cyc - start_cyc, 13);

    // R10: start while busy is ignored
    run(16'h0300, 16'd8, 10, 7);
    chk(vcount == 10, "R10 start while busy ignored", vcount, 10);

    // R10: zero length ignored
    vcount = 0;
    step(1'b1, 16'h0055, 16'd1, '0);
    for (int i = 0; i < 20; i++) step(1'b0, '0, '0, '0);
    chk(vcount == 0, "R10 zero length ignored", vcount, 0);
    chk(busy == 0, "R10 busy after zero length", busy, 0);

    // back-to-back loads right after busy drops
    run(16'h0400, 16'd4, 12, 0);
    run(16'h0401, 16'd7, 12, 0);
    for (int i = 0; i < 4; i++) step(1'b0, '0, '0, '0);
    finish_run();
  end
endmodule